// File: doc/BRIEF.md
# DSP Core Status Flag Register

This block is the 16-bit status word of a processor core that pairs an integer ALU with two DSP accumulators. Every cycle it can take flag results from the ALU: negative, overflow, zero, carry and half carry. From each accumulator it can take an overflow result and a saturation event. It also follows a loop-active line from the hardware loop controller and a ready-status line. Software rewrites the word through a plain write port. A size hint on that port limits a write to the low byte.

Each accumulator has an overflow flag and a saturation flag. The saturation flags are sticky and stay set until software clears them. Two summary bits give the OR of the overflow flags and the OR of the saturation flags. Writing 0 to the saturation summary clears both saturation flags at once. A 3-bit interrupt priority field can be frozen by an external nesting-disable control. That field, joined to an external fourth priority bit, forms the CPU priority level.

Top module: `dsp_status_reg`

Bit map of `status` (software decodes these positions): [15] ovf A, [14] ovf B, [13] sat A, [12] sat B, [11] ovf any, [10] sat any, [9] loop active, [8] half carry, [7:5] priority, [4] ready, [3] N, [2] OV, [1] Z, [0] C.

## Requirements
- R1: After synchronous reset, `status` reads 16'h0000.
- R2: When `alu_upd` is 1, N, OV, Z and C (bits 3..0) take `alu_n`, `alu_ov`, `alu_z` and `alu_c` on the next clock. With `alu_upd` at 0 they hold.
- R3: On an ALU update, half carry (bit 8) takes `alu_carries[3]` when `alu_byte` is 1 and `alu_carries[7]` when it is 0.
- R4: When `acc_a_upd` (or `acc_b_upd`) is 1, bit 15 (or bit 14) takes `acc_a_ovf` (or `acc_b_ovf`) on the next clock. Otherwise the bit holds.
- R5: An update carrying a saturation event sets bit 13 (A) or bit 12 (B). The bit then stays 1 through any number of later updates and ALU activity until software clears it.
- R6: Bit 11 always equals bit 15 OR bit 14. Bit 10 always equals bit 13 OR bit 12.
- R7: A word write with `wr_data[10]`=0 while bit 10 reads 1 clears bits 13 and 12 together. Any other word write loads bits 13 and 12 from `wr_data[13]` and `wr_data[12]`.
- R8: A saturation event in the same cycle as a software write to that saturation bit wins and leaves the bit set. For every other writable bit, a same-cycle software write wins over the hardware update.
- R9: While `nest_disable` is 1, writes leave the priority field (bits 7..5) unchanged. While it is 0, any write loads it from `wr_data[7:5]`.
- R10: `cpu_prio` equals {`prio_hi`, status[7:5]}.
- R11: Bit 9 shows `loop_active` and bit 4 shows `ra_in`, each one clock later. Writes to bits 11, 10 (apart from the clear of R7), 9 and 4 have no effect.
- R12: A write with `wr_byte`=1 changes only bits 7..0 (N, OV, Z, C and the unlocked priority). A write with `wr_byte`=0 covers the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_n | input | 1 | ALU negative result |
| alu_ov | input | 1 | ALU signed overflow result |
| alu_z | input | 1 | ALU zero result |
| alu_c | input | 1 | ALU carry result |
| alu_byte | input | 1 | 1 = byte-sized ALU operation, 0 = word-sized |
| alu_carries | input | 8 | Carry out of each of the low eight adder bit positions |
| acc_a_upd | input | 1 | Accumulator A flag update strobe |
| acc_a_ovf | input | 1 | Accumulator A overflow result |
| acc_a_sat | input | 1 | Accumulator A saturation event |
| acc_b_upd | input | 1 | Accumulator B flag update strobe |
| acc_b_ovf | input | 1 | Accumulator B overflow result |
| acc_b_sat | input | 1 | Accumulator B saturation event |
| loop_active | input | 1 | Hardware loop in progress |
| ra_in | input | 1 | Ready status from the core |
| wr_en | input | 1 | Software write strobe |
| wr_byte | input | 1 | 1 = write low byte only, 0 = write whole word |
| wr_data | input | 16 | Software write data |
| nest_disable | input | 1 | Freezes the priority field when 1 |
| prio_hi | input | 1 | Fourth priority bit from a separate control register |
| status | output | 16 | Read view of the status word |
| cpu_prio | output | 4 | Effective CPU priority level |

## Verification
The bench first drives directed patterns. These are an overflow-only update and a saturating update followed by several clean updates, which separate the latched overflow from the sticky saturation. Carry vectors with only bit 3 or only bit 7 set, tried under both size hints, show which carry position feeds the half carry. Writes that collide in one cycle with a saturation event or an ALU update test each side of the priority rule. The same priority write, tried with the lock on and then off, shows the field is frozen only while locked. A long run of seeded random updates and writes follows, with every input able to fire in any cycle. It compares the whole word and the priority level each cycle against a bench model built from the requirements.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int STAT_W   = 16;
    localparam int PRIO_W   = 3;
    localparam int CARRY_W  = 8;
    localparam int NUM_ACC  = 2;

    localparam int BIT_OA   = 15;
    localparam int BIT_SA   = 13;
    localparam int BIT_OAB  = 11;
    localparam int BIT_SAB  = 10;
    localparam int BIT_DA   = 9;
    localparam int BIT_DC   = 8;
    localparam int BIT_PRIO = 5;
    localparam int BIT_RA   = 4;
    localparam int BIT_N    = 3;
    localparam int BIT_OV   = 2;
    localparam int BIT_Z    = 1;
    localparam int BIT_C    = 0;

    localparam int HC_BYTE_BIT = 3;
    localparam int HC_WORD_BIT = 7;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic c;
        logic dc;
    } alu_flags_t;

    typedef struct packed {
        logic upd;
        logic ovf;
        logic sat;
    } acc_evt_t;

    typedef struct packed {
        logic ovf;
        logic sat;
    } acc_flags_t;

    function automatic logic half_carry(input logic [CARRY_W-1:0] cy, input logic byte_op);
        return byte_op ? cy[HC_BYTE_BIT] : cy[HC_WORD_BIT];
    endfunction

endpackage

// File: rtl/dsr_alu_flags.sv
module dsr_alu_flags
    import dsr_pkg::*;
#(
    parameter int CW = CARRY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  alu_flags_t    hw_in,
    input  logic [CW-1:0] carries,
    input  logic          byte_op,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [3:0]    wr_nzvc,
    input  logic          wr_dc,
    output alu_flags_t    q
);

    alu_flags_t hw_eff;
    alu_flags_t nxt;

    always_comb begin
        hw_eff    = hw_in;
        hw_eff.dc = half_carry(carries, byte_op);
        nxt       = q;
        if (upd) begin
            nxt = hw_eff;
        end
        // software has priority over the ALU on these bits
        if (wr_lo) begin
            nxt.n  = wr_nzvc[3];
            nxt.ov = wr_nzvc[2];
            nxt.z  = wr_nzvc[1];
            nxt.c  = wr_nzvc[0];
        end
        if (wr_hi) begin
            nxt.dc = wr_dc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/dsr_acc_flags.sv
module dsr_acc_flags
    import dsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acc_evt_t   evt,
    input  logic       sw_wr,
    input  logic       sw_ovf,
    input  logic       sw_sat,
    input  logic       sat_clear,
    output acc_flags_t q
);

    acc_flags_t nxt;

    always_comb begin
        nxt = q;
        if (sw_wr) begin
            nxt.ovf = sw_ovf;
        end else if (evt.upd) begin
            nxt.ovf = evt.ovf;
        end
        // a saturation event beats any same-cycle software action
        if (evt.upd && evt.sat) begin
            nxt.sat = 1'b1;
        end else if (sat_clear) begin
            nxt.sat = 1'b0;
        end else if (sw_wr) begin
            nxt.sat = sw_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/dsr_prio_field.sv
module dsr_prio_field
    import dsr_pkg::*;
#(
    parameter int PW = PRIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          lock,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr && !lock) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/dsp_status_reg.sv
module dsp_status_reg
    import dsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alu_upd,
    input  logic               alu_n,
    input  logic               alu_ov,
    input  logic               alu_z,
    input  logic               alu_c,
    input  logic               alu_byte,
    input  logic [CARRY_W-1:0] alu_carries,
    input  logic               acc_a_upd,
    input  logic               acc_a_ovf,
    input  logic               acc_a_sat,
    input  logic               acc_b_upd,
    input  logic               acc_b_ovf,
    input  logic               acc_b_sat,
    input  logic               loop_active,
    input  logic               ra_in,
    input  logic               wr_en,
    input  logic               wr_byte,
    input  logic [STAT_W-1:0]  wr_data,
    input  logic               nest_disable,
    input  logic               prio_hi,
    output logic [STAT_W-1:0]  status,
    output logic [PRIO_W:0]    cpu_prio
);

    logic wr_lo;
    logic wr_hi;
    logic sab_now;
    logic sat_clear;
    logic da_q;
    logic ra_q;
    logic wr_ignored_unused;

    alu_flags_t              alu_hw;
    alu_flags_t              alu_q;
    acc_evt_t   [NUM_ACC-1:0] acc_evt;
    acc_flags_t [NUM_ACC-1:0] acc_q;
    logic       [PRIO_W-1:0] prio_q;

    assign wr_lo = wr_en;
    assign wr_hi = wr_en && !wr_byte;
    assign wr_ignored_unused = ^{wr_data[BIT_OAB], wr_data[BIT_DA], wr_data[BIT_RA]};

    always_comb begin
        alu_hw    = '0;
        alu_hw.n  = alu_n;
        alu_hw.ov = alu_ov;
        alu_hw.z  = alu_z;
        alu_hw.c  = alu_c;
    end

    assign acc_evt[0] = '{upd: acc_a_upd, ovf: acc_a_ovf, sat: acc_a_sat};
    assign acc_evt[1] = '{upd: acc_b_upd, ovf: acc_b_ovf, sat: acc_b_sat};

    always_comb begin
        sab_now = 1'b0;
        for (int i = 0; i < NUM_ACC; i++) begin
            sab_now = sab_now | acc_q[i].sat;
        end
    end

    // writing 0 to the summary while it reads 1 clears every saturation flag
    assign sat_clear = wr_hi && !wr_data[BIT_SAB] && sab_now;

    dsr_alu_flags u_alu (
        .clk     (clk),
        .rst     (rst),
        .upd     (alu_upd),
        .hw_in   (alu_hw),
        .carries (alu_carries),
        .byte_op (alu_byte),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_nzvc (wr_data[BIT_N:BIT_C]),
        .wr_dc   (wr_data[BIT_DC]),
        .q       (alu_q)
    );

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        dsr_acc_flags u_acc (
            .clk       (clk),
            .rst       (rst),
            .evt       (acc_evt[g]),
            .sw_wr     (wr_hi),
            .sw_ovf    (wr_data[BIT_OA-g]),
            .sw_sat    (wr_data[BIT_SA-g]),
            .sat_clear (sat_clear),
            .q         (acc_q[g])
        );
    end

    dsr_prio_field u_prio (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_lo),
        .lock  (nest_disable),
        .wdata (wr_data[BIT_PRIO+PRIO_W-1:BIT_PRIO]),
        .q     (prio_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            da_q <= 1'b0;
            ra_q <= 1'b0;
        end else begin
            da_q <= loop_active;
            ra_q <= ra_in;
        end
    end

    always_comb begin
        status = '0;
        for (int i = 0; i < NUM_ACC; i++) begin
            status[BIT_OA-i] = acc_q[i].ovf;
            status[BIT_SA-i] = acc_q[i].sat;
            status[BIT_OAB]  = status[BIT_OAB] | acc_q[i].ovf;
            status[BIT_SAB]  = status[BIT_SAB] | acc_q[i].sat;
        end
        status[BIT_DA]                          = da_q;
        status[BIT_DC]                          = alu_q.dc;
        status[BIT_PRIO+PRIO_W-1:BIT_PRIO]      = prio_q;
        status[BIT_RA]                          = ra_q;
        status[BIT_N]                           = alu_q.n;
        status[BIT_OV]                          = alu_q.ov;
        status[BIT_Z]                           = alu_q.z;
        status[BIT_C]                           = alu_q.c;
    end

    assign cpu_prio = {prio_hi, prio_q};

endmodule

// File: rtl/dsr_status_chk.sv
module dsr_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_byte,
    input logic [15:0] wr_data,
    input logic        alu_upd,
    input logic        acc_a_upd,
    input logic        acc_a_sat,
    input logic        acc_b_upd,
    input logic        acc_b_sat,
    input logic        loop_active,
    input logic        nest_disable,
    input logic [15:0] status
);

    logic chk_unused;
    assign chk_unused = ^{wr_data[15:11], wr_data[9:0], status[11], status[4:0]};

    // R5: saturation flags survive every cycle without a word write
    p_sticky_a_r5: assert property (@(posedge clk) disable iff (rst)
        (status[13] && !(wr_en && !wr_byte)) |=> status[13]);
    p_sticky_b_r5: assert property (@(posedge clk) disable iff (rst)
        (status[12] && !(wr_en && !wr_byte)) |=> status[12]);

    // R7: summary clear drops both saturation flags
    p_sab_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_byte && !wr_data[10] && status[10]
         && !(acc_a_upd && acc_a_sat) && !(acc_b_upd && acc_b_sat))
        |=> (status[13:12] == 2'b00));

    // R8: a saturation event always leaves its flag set
    p_hw_wins_a_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_a_upd && acc_a_sat) |=> status[13]);
    p_hw_wins_b_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_b_upd && acc_b_sat) |=> status[12]);

    // R9: locked priority field does not move
    p_ipl_lock_r9: assert property (@(posedge clk) disable iff (rst)
        nest_disable |=> $stable(status[7:5]));

    // R11: loop-active bit follows its input one clock later
    p_loop_follow_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (status[9] == $past(loop_active)));

    // R12: byte writes never reach the upper byte's flags
    p_byte_wr_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_byte && !alu_upd && !acc_a_upd && !acc_b_upd)
        |=> $stable({status[15:12], status[8]}));

endmodule

bind dsp_status_reg dsr_status_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_byte      (wr_byte),
    .wr_data      (wr_data),
    .alu_upd      (alu_upd),
    .acc_a_upd    (acc_a_upd),
    .acc_a_sat    (acc_a_sat),
    .acc_b_upd    (acc_b_upd),
    .acc_b_sat    (acc_b_sat),
    .loop_active  (loop_active),
    .nest_disable (nest_disable),
    .status       (status)
);

// File: tb/dsp_status_reg_bench.sv
module dsp_status_reg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alu_upd, alu_n, alu_ov, alu_z, alu_c, alu_byte;
    logic [7:0]  alu_carries;
    logic        acc_a_upd, acc_a_ovf, acc_a_sat;
    logic        acc_b_upd, acc_b_ovf, acc_b_sat;
    logic        loop_active, ra_in;
    logic        wr_en, wr_byte;
    logic [15:0] wr_data;
    logic        nest_disable, prio_hi;
    logic [15:0] status;
    logic [3:0]  cpu_prio;

    int checks   = 0;
    int failures = 0;
    logic [15:0] exp_s = 16'h0000;

    always #2 clk = ~clk;

    dsp_status_reg u_dsp_status_reg (
        .clk(clk), .rst(rst),
        .alu_upd(alu_upd), .alu_n(alu_n), .alu_ov(alu_ov), .alu_z(alu_z),
        .alu_c(alu_c), .alu_byte(alu_byte), .alu_carries(alu_carries),
        .acc_a_upd(acc_a_upd), .acc_a_ovf(acc_a_ovf), .acc_a_sat(acc_a_sat),
        .acc_b_upd(acc_b_upd), .acc_b_ovf(acc_b_ovf), .acc_b_sat(acc_b_sat),
        .loop_active(loop_active), .ra_in(ra_in),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_data(wr_data),
        .nest_disable(nest_disable), .prio_hi(prio_hi),
        .status(status), .cpu_prio(cpu_prio)
    );

    // next word according to the requirements, from the inputs now driven
    function automatic logic [15:0] model_next(input logic [15:0] s);
        logic [15:0] n;
        n = s;
        if (alu_upd) begin
            n[3:0] = {alu_n, alu_ov, alu_z, alu_c};
            n[8]   = alu_byte ? alu_carries[3] : alu_carries[7];
        end
        if (acc_a_upd) n[15] = acc_a_ovf;
        if (acc_b_upd) n[14] = acc_b_ovf;
        if (wr_en) begin
            n[3:0] = wr_data[3:0];
            if (!nest_disable) n[7:5] = wr_data[7:5];
            if (!wr_byte) begin
                n[15:14] = wr_data[15:14];
                n[8]     = wr_data[8];
                if ((s[13] | s[12]) && !wr_data[10]) n[13:12] = 2'b00;
                else                                  n[13:12] = wr_data[13:12];
            end
        end
        if (acc_a_upd && acc_a_sat) n[13] = 1'b1;
        if (acc_b_upd && acc_b_sat) n[12] = 1'b1;
        n[9]  = loop_active;
        n[4]  = ra_in;
        n[11] = n[15] | n[14];
        n[10] = n[13] | n[12];
        return n;
    endfunction

    task automatic check_word(input string tag);
        checks++;
        if (status !== exp_s) begin
            failures++;
            $display("FAIL %s status actual=%h expected=%h", tag, status, exp_s);
        end
        checks++;
        if (cpu_prio !== {prio_hi, exp_s[7:5]}) begin
            failures++;
            $display("FAIL R10 cpu_prio actual=%h expected=%h", cpu_prio, {prio_hi, exp_s[7:5]});
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, expv);
        end
    endtask

    task automatic idle_inputs();
        alu_upd = 0; alu_n = 0; alu_ov = 0; alu_z = 0; alu_c = 0; alu_byte = 0;
        alu_carries = 8'h00;
        acc_a_upd = 0; acc_a_ovf = 0; acc_a_sat = 0;
        acc_b_upd = 0; acc_b_ovf = 0; acc_b_sat = 0;
        loop_active = 0; ra_in = 0;
        wr_en = 0; wr_byte = 0; wr_data = 16'h0000;
        nest_disable = 0; prio_hi = 0;
    endtask

    task automatic tick(input string tag);
        logic [15:0] nx;
        nx = model_next(exp_s);
        @(posedge clk);
        #1;
        exp_s = nx;
        check_word(tag);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4127));
        idle_inputs();
        rst = 1'b1;
        loop_active = 1; ra_in = 1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_bit("R1 reset word zero", status == 16'h0000, 1'b1);
        loop_active = 0; ra_in = 0;
        tick("R1 idle after reset");

        // R2: ALU flag load and hold
        alu_upd = 1; alu_n = 1; alu_z = 1;
        tick("R2 alu load");
        check_bit("R2 N set", status[3], 1'b1);
        alu_upd = 0; alu_n = 0; alu_z = 0;
        tick("R2 alu hold");
        check_bit("R2 Z held", status[1], 1'b1);

        // R3: half carry position depends on size hint
        alu_upd = 1; alu_carries = 8'h80; alu_byte = 0;
        tick("R3 word carry7");
        check_bit("R3 word dc", status[8], 1'b1);
        alu_byte = 1;
        tick("R3 byte ignores carry7");
        check_bit("R3 byte dc clear", status[8], 1'b0);
        alu_carries = 8'h08;
        tick("R3 byte carry3");
        check_bit("R3 byte dc set", status[8], 1'b1);
        alu_byte = 0;
        tick("R3 word ignores carry3");
        check_bit("R3 word dc clear", status[8], 1'b0);
        idle_inputs();

        // R4/R5: overflow follows, saturation sticks
        acc_a_upd = 1; acc_a_ovf = 1; acc_a_sat = 1;
        tick("R4 R5 acc A sat event");
        check_bit("R6 ovf summary", status[11], 1'b1);
        acc_a_ovf = 0; acc_a_sat = 0; alu_upd = 1;
        for (int k = 0; k < 5; k++) tick("R5 sticky across updates");
        check_bit("R4 ovf A follows", status[15], 1'b0);
        check_bit("R5 sat A sticky", status[13], 1'b1);
        check_bit("R6 sat summary", status[10], 1'b1);
        idle_inputs();

        // R7: summary clear, then direct write
        acc_b_upd = 1; acc_b_sat = 1;
        tick("R5 acc B sat event");
        idle_inputs();
        wr_en = 1; wr_data = 16'h3000;
        tick("R7 clear both");
        check_bit("R7 sat A cleared", status[13], 1'b0);
        check_bit("R7 sat B cleared", status[12], 1'b0);
        wr_data = 16'h2000;
        tick("R7 direct write sat A");
        check_bit("R7 sat A written", status[13], 1'b1);

        // R8: collisions
        wr_data = 16'h0000; acc_a_upd = 1; acc_a_sat = 1;
        tick("R8 sat event beats clear");
        check_bit("R8 sat A kept", status[13], 1'b1);
        idle_inputs();
        wr_en = 1; wr_byte = 1; wr_data = 16'h0000; alu_upd = 1; alu_c = 1;
        tick("R8 write beats alu carry");
        check_bit("R8 C from write", status[0], 1'b0);
        idle_inputs();

        // R9/R10: priority lock
        wr_en = 1; wr_byte = 1; wr_data = 16'h00A0; nest_disable = 0; prio_hi = 1;
        tick("R9 R10 unlocked write");
        wr_data = 16'h0040; nest_disable = 1;
        tick("R9 locked write");
        check_bit("R9 prio kept", status[7:5] == 3'b101, 1'b1);
        check_bit("R10 prio level", cpu_prio == 4'b1101, 1'b1);
        idle_inputs();

        // R11: read-only bits
        wr_en = 1; wr_data = 16'h0E10; loop_active = 1;
        tick("R11 write ignored loop follows");
        check_bit("R11 DA follows", status[9], 1'b1);
        check_bit("R11 RA ignored", status[4], 1'b0);
        idle_inputs();

        // R12: byte write leaves upper byte
        wr_en = 1; wr_byte = 1; wr_data = 16'hF3FF;
        tick("R12 byte write");
        check_bit("R12 ovf A untouched", status[15], 1'b0);
        idle_inputs();

        // random mix
        for (int k = 0; k < 3000; k++) begin
            alu_upd = 1'($urandom); alu_n = 1'($urandom); alu_ov = 1'($urandom);
            alu_z = 1'($urandom); alu_c = 1'($urandom); alu_byte = 1'($urandom);
            alu_carries = 8'($urandom);
            acc_a_upd = 1'($urandom); acc_a_ovf = 1'($urandom); acc_a_sat = ($urandom % 6) == 0;
            acc_b_upd = 1'($urandom); acc_b_ovf = 1'($urandom); acc_b_sat = ($urandom % 6) == 0;
            loop_active = 1'($urandom); ra_in = 1'($urandom);
            wr_en = ($urandom % 4) == 0; wr_byte = 1'($urandom); wr_data = 16'($urandom);
            nest_disable = 1'($urandom); prio_hi = 1'($urandom);
            tick("R2 R3 R4 R5 R7 R8 R9 R12 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule